// File: doc/BRIEF.md
# ADC Scan Sequencer with Result Accumulator

This block drives an external successive-approximation converter through a simple request/done handshake. The converter returns a 12-bit code. A scan table of up to eight slots is walked in order, with no software help between slots. Each slot names an input channel and picks one of four conversion profiles. A profile gives the resolution (12-bit or 10-bit), the number of conversions to sum (1 to 16) and, for burst operation, a settling delay. When a slot has finished, its summed result is formatted, right- or left-justified, and compared against a high and a low threshold. The result is then pushed into an eight-entry result FIFO, which a DMA engine or software drains through a read strobe.

A scan step starts on a software start pulse, or on a rising edge of a hardware trigger when that source is enabled. In burst mode, one trigger waits out the settling delay and then runs every conversion the slot's profile asks for, back to back. In single-step mode, each conversion needs its own trigger, and the sum is kept across triggers until the count is reached. Six sticky status flags record events. Each flag is cleared by writing 1 to it. Each flag has an interrupt enable, and the enabled flags are ORed into one interrupt line.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, adc_req is 0, fifo_level is 0, all flags are 0, irq is 0, and the scan starts at slot 0.
- R2: Slots 0 up to cfg_last_slot are converted in ascending order and the scan then wraps back to slot 0. While a request is issued, adc_chan carries that slot's channel and adc_mode10 carries its profile's resolution bit (1 = 10-bit). Slot s selects its profile with cfg_slot_prof[2s+1:2s].
- R3: A software trigger that is sampled at clock edge E starts the first request. In single-step mode, adc_req is high in the cycle after E. In burst mode, adc_req goes high S+1 cycles later than that, where S is the profile's settle count in cfg_prof_settle[8p+7:8p]. A hardware rising edge takes two further cycles to pass through its synchronizer.
- R4: In burst mode, a single trigger runs all N conversions of the slot. Each new request is raised in the cycle after the previous adc_done, and exactly one result is produced for that trigger.
- R5: In single-step mode, each conversion is started only by a trigger. The result is produced after the Nth triggered conversion.
- R6: N equals cfg_prof_acc[4p+3:4p] plus 1. The result is the sum of the N samples. A sample is adc_data in 12-bit mode and adc_data[11:2] in 10-bit mode.
- R7: With cfg_left_just set, the 16-bit output word is the sum shifted left by 4 (12-bit profile) or by 6 (10-bit profile), with bits above bit 15 dropped. Otherwise the word is the sum itself.
- R8: For each result, flag bit 4 is set if the unshifted sum is greater than cfg_thr_hi, and flag bit 5 is set if the unshifted sum is less than cfg_thr_lo.
- R9: The FIFO holds up to FIFO_DEPTH words and returns them in arrival order. A fifo_rd pulse in one cycle places the oldest word on fifo_rdata in the next cycle, and fifo_level gives the occupancy.
- R10: A result that arrives while the FIFO is full and not being read is dropped, fifo_level stays at FIFO_DEPTH, and flag bit 2 is set.
- R11: A read of an empty FIFO leaves fifo_rdata at the last word read and sets flag bit 3.
- R12: Flag bit 0 is set on every adc_done accepted during a conversion, and flag bit 1 on every finished result. Writing 1 to a bit of flag_clr clears that flag. A set event in the same cycle wins over the clear.
- R13: irq is high exactly when some flag bit is set and its irq_en bit is also set.
- R14: A trigger that arrives while a slot is busy is ignored. A hardware trigger edge has no effect while cfg_hw_trig_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_start | input | 1 | Software trigger pulse |
| hw_trig | input | 1 | Asynchronous hardware trigger level |
| cfg_hw_trig_en | input | 1 | Enables hardware trigger edges |
| cfg_burst | input | 1 | 1 = burst mode, 0 = single-step mode |
| cfg_left_just | input | 1 | Left-justify output words |
| cfg_last_slot | input | $clog2(SLOTS) | Index of the final slot in the scan |
| cfg_slot_chan | input | SLOTS*CH_W | Channel number for each slot |
| cfg_slot_prof | input | SLOTS*2 | Profile selector for each slot |
| cfg_prof_mode10 | input | 4 | 10-bit mode bit for each profile |
| cfg_prof_acc | input | 16 | Conversion count minus one for each profile |
| cfg_prof_settle | input | 32 | Burst settle cycles for each profile |
| cfg_thr_hi | input | 16 | High threshold |
| cfg_thr_lo | input | 16 | Low threshold |
| adc_req | output | 1 | One-cycle conversion request |
| adc_chan | output | CH_W | Channel of the current slot |
| adc_mode10 | output | 1 | Resolution of the current slot |
| adc_done | input | 1 | Conversion-finished pulse |
| adc_data | input | 12 | Converter code |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_rdata | output | 16 | Last word read |
| fifo_level | output | $clog2(FIFO_DEPTH+1) | FIFO occupancy |
| flags | output | 6 | Sticky status flags |
| flag_clr | input | 6 | Write-1-to-clear strobes |
| irq_en | input | 6 | Interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: SLOTS=8, CH_W=5 and FIFO_DEPTH=8. With eight slots, a full scan followed by its wrap back to slot 0 can be walked in a few hundred cycles. With eight FIFO entries, the ninth unread result reaches the overflow case, and the underflow case follows once the FIFO is drained. Random profiles use counts up to 16 with full-scale codes, so the 16-bit sum and the truncating left shift are exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NPROF    = 4;
    localparam int PROF_W   = $clog2(NPROF);
    localparam int CNT_W    = 4;
    localparam int SETTLE_W = 8;
    localparam int CODE_W   = 12;
    localparam int SUM_W    = 16;
    localparam int NFLAGS   = 6;

    localparam int FLG_CONV = 0;
    localparam int FLG_RES  = 1;
    localparam int FLG_OVF  = 2;
    localparam int FLG_UNF  = 3;
    localparam int FLG_HI   = 4;
    localparam int FLG_LO   = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic                mode10;
        logic [CNT_W-1:0]    acc_m1;
        logic [SETTLE_W-1:0] settle;
    } prof_t;

    function automatic logic [CODE_W-1:0] take_sample(input logic [CODE_W-1:0] code,
                                                      input logic mode10);
        return mode10 ? {2'b00, code[CODE_W-1:2]} : code;
    endfunction

    function automatic logic [SUM_W-1:0] format_word(input logic [SUM_W-1:0] sum,
                                                     input logic mode10,
                                                     input logic left);
        if (!left)
            return sum;
        return mode10 ? (sum << 6) : (sum << 4);
    endfunction

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    input  logic enable,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = enable & sync_q & ~prev_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CH_W  = 5,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    trig,
    input  logic                    cfg_burst,
    input  logic [SLOT_W-1:0]       cfg_last_slot,
    input  logic [SLOTS*CH_W-1:0]   slot_chan,
    input  logic [SLOTS*PROF_W-1:0] slot_prof,
    input  prof_t                   prof [NPROF],
    output logic                    adc_req,
    output logic [CH_W-1:0]         adc_chan,
    output logic                    adc_mode10,
    input  logic                    adc_done,
    input  logic [CODE_W-1:0]       adc_data,
    output logic                    conv_done,
    output logic                    res_valid,
    output logic [SUM_W-1:0]        res_sum,
    output logic                    res_mode10
);
    seq_state_e          state;
    logic [SLOT_W-1:0]   cur;
    logic [SUM_W-1:0]    acc;
    logic [CNT_W-1:0]    cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                burst_q;

    prof_t             p;
    logic [SUM_W-1:0]  sum_next;
    logic              last_conv;
    logic [SLOT_W-1:0] next_slot;

    always_comb begin
        p         = prof[slot_prof[int'(cur)*PROF_W +: PROF_W]];
        adc_chan  = slot_chan[int'(cur)*CH_W +: CH_W];
        adc_mode10 = p.mode10;
        adc_req   = (state == ST_REQ);
        sum_next  = acc + {{(SUM_W-CODE_W){1'b0}}, take_sample(adc_data, p.mode10)};
        last_conv = (cnt == p.acc_m1);
        next_slot = (cur == cfg_last_slot) ? '0 : cur + SLOT_W'(1);
        conv_done = (state == ST_WAIT) && adc_done;
        res_valid = conv_done && last_conv;
        res_sum   = sum_next;
        res_mode10 = p.mode10;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            acc        <= '0;
            cnt        <= '0;
            settle_cnt <= '0;
            burst_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (trig) begin
                    burst_q <= cfg_burst;
                    if (cfg_burst) begin
                        settle_cnt <= p.settle;
                        state      <= ST_SETTLE;
                    end else begin
                        state <= ST_REQ;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == '0) state <= ST_REQ;
                    else                  settle_cnt <= settle_cnt - SETTLE_W'(1);
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: if (adc_done) begin
                    if (last_conv) begin
                        acc   <= '0;
                        cnt   <= '0;
                        cur   <= next_slot;
                        state <= ST_IDLE;
                    end else begin
                        acc   <= sum_next;
                        cnt   <= cnt + CNT_W'(1);
                        state <= burst_q ? ST_REQ : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: a request lasts exactly one cycle
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        adc_req |=> !adc_req);

    // R5: in single-step mode every request follows a trigger
    assert_step_trig_R5: assert property (@(posedge clk) disable iff (rst)
        (adc_req && !burst_q) |-> $past(trig));

    // R2: the channel does not move while a conversion is outstanding
    assert_chan_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT) |-> $stable(adc_chan));
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH+1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    always_comb begin
        full    = (level == LW'(DEPTH));
        empty   = (level == '0);
        do_pop  = rd & ~empty;
        do_push = wr & (~full | do_pop);
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            rdata <= '0;
        end else begin
            if (do_push)
                wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            if (do_pop) begin
                rdata <= mem[rptr];
                rptr  <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            end
            if (do_push && !do_pop)      level <= level + LW'(1);
            else if (do_pop && !do_push) level <= level - LW'(1);
        end
    end

    // R9: occupancy never passes the depth
    assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R10: a write into a full, unread FIFO changes nothing
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> $stable(level));

    // R11: reading an empty FIFO keeps the previous word
    assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && empty) |=> $stable(rdata));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int SLOTS      = 8,
    parameter int CH_W       = 5,
    parameter int FIFO_DEPTH = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int LVL_W  = $clog2(FIFO_DEPTH+1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sw_start,
    input  logic                      hw_trig,
    input  logic                      cfg_hw_trig_en,
    input  logic                      cfg_burst,
    input  logic                      cfg_left_just,
    input  logic [SLOT_W-1:0]         cfg_last_slot,
    input  logic [SLOTS*CH_W-1:0]     cfg_slot_chan,
    input  logic [SLOTS*PROF_W-1:0]   cfg_slot_prof,
    input  logic [NPROF-1:0]          cfg_prof_mode10,
    input  logic [NPROF*CNT_W-1:0]    cfg_prof_acc,
    input  logic [NPROF*SETTLE_W-1:0] cfg_prof_settle,
    input  logic [SUM_W-1:0]          cfg_thr_hi,
    input  logic [SUM_W-1:0]          cfg_thr_lo,
    output logic                      adc_req,
    output logic [CH_W-1:0]           adc_chan,
    output logic                      adc_mode10,
    input  logic                      adc_done,
    input  logic [CODE_W-1:0]         adc_data,
    input  logic                      fifo_rd,
    output logic [SUM_W-1:0]          fifo_rdata,
    output logic [LVL_W-1:0]          fifo_level,
    output logic [NFLAGS-1:0]         flags,
    input  logic [NFLAGS-1:0]         flag_clr,
    input  logic [NFLAGS-1:0]         irq_en,
    output logic                      irq
);
    prof_t prof [NPROF];

    for (genvar g = 0; g < NPROF; g++) begin : g_prof
        assign prof[g].mode10 = cfg_prof_mode10[g];
        assign prof[g].acc_m1 = cfg_prof_acc[g*CNT_W +: CNT_W];
        assign prof[g].settle = cfg_prof_settle[g*SETTLE_W +: SETTLE_W];
    end

    logic             hw_rise, trig;
    logic             conv_done, res_valid, res_mode10;
    logic [SUM_W-1:0] res_sum, res_word;
    logic             fifo_full, fifo_empty;
    logic [NFLAGS-1:0] set_v;

    adc_trig_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (hw_trig),
        .enable   (cfg_hw_trig_en),
        .rise     (hw_rise)
    );

    assign trig = sw_start | hw_rise;

    adc_seq_ctrl #(.SLOTS(SLOTS), .CH_W(CH_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .trig          (trig),
        .cfg_burst     (cfg_burst),
        .cfg_last_slot (cfg_last_slot),
        .slot_chan     (cfg_slot_chan),
        .slot_prof     (cfg_slot_prof),
        .prof          (prof),
        .adc_req       (adc_req),
        .adc_chan      (adc_chan),
        .adc_mode10    (adc_mode10),
        .adc_done      (adc_done),
        .adc_data      (adc_data),
        .conv_done     (conv_done),
        .res_valid     (res_valid),
        .res_sum       (res_sum),
        .res_mode10    (res_mode10)
    );

    assign res_word = format_word(res_sum, res_mode10, cfg_left_just);

    adc_result_fifo #(.DEPTH(FIFO_DEPTH), .W(SUM_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .wr    (res_valid),
        .wdata (res_word),
        .rd    (fifo_rd),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        set_v           = '0;
        set_v[FLG_CONV] = conv_done;
        set_v[FLG_RES]  = res_valid;
        set_v[FLG_OVF]  = res_valid & fifo_full & ~fifo_rd;
        set_v[FLG_UNF]  = fifo_rd & fifo_empty;
        set_v[FLG_HI]   = res_valid & (res_sum > cfg_thr_hi);
        set_v[FLG_LO]   = res_valid & (res_sum < cfg_thr_lo);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | set_v;
    end

    assign irq = |(flags & irq_en);

    // R10: a dropped result leaves the overflow flag raised
    assert_ovf_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (res_valid && fifo_full && !fifo_rd) |=> flags[FLG_OVF]);

    // R11: an empty read leaves the underflow flag raised
    assert_unf_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fifo_empty) |=> flags[FLG_UNF]);
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 8;
    localparam int CH_W  = 5;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sw_start = 0, hw_trig = 0, cfg_hw_trig_en = 0, cfg_burst = 0, cfg_left_just = 0;
    logic [2:0]  cfg_last_slot = 0;
    logic [SLOTS*CH_W-1:0] cfg_slot_chan = 0;
    logic [SLOTS*2-1:0]    cfg_slot_prof = 0;
    logic [3:0]  cfg_prof_mode10 = 0;
    logic [15:0] cfg_prof_acc = 0;
    logic [31:0] cfg_prof_settle = 0;
    logic [15:0] cfg_thr_hi = 16'hFFFF, cfg_thr_lo = 0;
    logic        adc_req, adc_mode10;
    logic [CH_W-1:0] adc_chan;
    logic        adc_done = 0;
    logic [11:0] adc_data = 0;
    logic        fifo_rd = 0;
    logic [15:0] fifo_rdata;
    logic [3:0]  fifo_level;
    logic [5:0]  flags;
    logic [5:0]  flag_clr = 0, irq_en = 0;
    logic        irq;

    adc_scan_seq #(.SLOTS(SLOTS), .CH_W(CH_W), .FIFO_DEPTH(DEPTH)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0, req_seen = 0;
    int chan_t[SLOTS], psel_t[SLOTS], m10_t[4], accm1_t[4], settle_t[4];
    int cur = 0;

    always @(posedge clk) if (adc_req) req_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_word(input int sum, input int m10, input bit left);
        if (!left) return sum;
        return ((m10 != 0) ? (sum << 6) : (sum << 4)) & 16'hFFFF;
    endfunction

    task automatic apply_cfg();
        for (int s = 0; s < SLOTS; s++) begin
            cfg_slot_chan[s*CH_W +: CH_W] = chan_t[s][CH_W-1:0];
            cfg_slot_prof[s*2 +: 2]       = psel_t[s][1:0];
        end
        for (int p = 0; p < 4; p++) begin
            cfg_prof_mode10[p]     = m10_t[p][0];
            cfg_prof_acc[p*4 +: 4] = accm1_t[p][3:0];
            cfg_prof_settle[p*8 +: 8] = settle_t[p][7:0];
        end
    endtask

    task automatic rand_cfg(input int max_settle);
        for (int s = 0; s < SLOTS; s++) begin
            chan_t[s] = $urandom % 32;
            psel_t[s] = $urandom % 4;
        end
        for (int p = 0; p < 4; p++) begin
            m10_t[p]    = $urandom % 2;
            accm1_t[p]  = $urandom % 16;
            settle_t[p] = $urandom % max_settle;
        end
        apply_cfg();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        cur = 0;
    endtask

    task automatic sw_trig();
        @(negedge clk) sw_start = 1;
        @(negedge clk) sw_start = 0;
    endtask

    task automatic clr(input logic [5:0] m);
        @(negedge clk) flag_clr = m;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic pop(output int v);
        @(negedge clk) fifo_rd = 1;
        @(negedge clk) fifo_rd = 0;
        v = fifo_rdata;
    endtask

    task automatic service(input logic [11:0] d, output int lat, output int ch, output int m);
        lat = 0;
        while (!adc_req && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
        ch = adc_chan;
        m  = adc_mode10;
        @(negedge clk) begin adc_done = 1; adc_data = d; end
        @(negedge clk) adc_done = 0;
    endtask

    // runs the current slot to its result; returns the unshifted sum and the mode
    task automatic run_slot(input bit burst, output int sum, output int m10);
        int p, lat, ch, m, d;
        p = psel_t[cur];
        sum = 0;
        m10 = m10_t[p];
        for (int k = 0; k <= accm1_t[p]; k++) begin
            if (!burst || k == 0) sw_trig();
            d = $urandom % 4096;
            service(d[11:0], lat, ch, m);
            chk("R2 channel", ch, chan_t[cur]);
            chk("R2 resolution", m, m10_t[p]);
            if (burst && k == 0) chk("R3 burst settle latency", lat, settle_t[p] + 1);
            else if (burst)      chk("R4 back-to-back latency", lat, 0);
            else                 chk("R5 step latency", lat, 0);
            sum += (m10 != 0) ? (d >> 2) : d;
        end
        cur = (cur == int'(cfg_last_slot)) ? 0 : cur + 1;
    endtask

    task automatic finish_tb();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        int sum, m10, v, lat, ch, m, last_v;
        int exp_q[$];
        void'($urandom(32'd20240611));

        // R1 reset state
        rand_cfg(8);
        do_reset();
        chk("R1 adc_req", adc_req, 0);
        chk("R1 fifo_level", fifo_level, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);

        // directed single-step scan over 3 slots with wrap, R2 R5 R6 R9
        cfg_last_slot = 2; cfg_burst = 0; cfg_left_just = 0;
        exp_q.delete();
        for (int i = 0; i < 4; i++) begin
            run_slot(0, sum, m10);
            exp_q.push_back(sum);
            chk("R9 level", fifo_level, i + 1);
        end
        for (int i = 0; i < 4; i++) begin
            pop(v);
            chk("R6 R9 result order", v, exp_q[i]);
        end

        // random scans, burst and single-step, justify, thresholds: R2-R8
        for (int it = 0; it < 20; it++) begin
            rand_cfg(12);
            cfg_last_slot = 3'($urandom % 8);
            cfg_burst     = 1'($urandom % 2);
            cfg_left_just = 1'($urandom % 2);
            cfg_thr_hi    = 16'($urandom % 40000);
            cfg_thr_lo    = 16'($urandom % 20000);
            do_reset();
            for (int s = 0; s <= int'(cfg_last_slot) + 1; s++) begin
                clr(6'h3F);
                run_slot(cfg_burst, sum, m10);
                chk("R8 high flag", flags[4], int'(sum > int'(cfg_thr_hi)));
                chk("R8 low flag", flags[5], int'(sum < int'(cfg_thr_lo)));
                chk("R9 level one", fifo_level, 1);
                pop(v);
                chk("R6 R7 word", v, exp_word(sum, m10, cfg_left_just));
            end
        end

        // R7 directed: full-scale 12-bit sum of 16 shifted left truncates
        for (int p = 0; p < 4; p++) begin m10_t[p] = 0; accm1_t[p] = 15; settle_t[p] = 0; end
        for (int s = 0; s < SLOTS; s++) psel_t[s] = 0;
        apply_cfg();
        cfg_burst = 1; cfg_left_just = 1; cfg_last_slot = 0;
        do_reset();
        sw_trig();
        for (int k = 0; k < 16; k++) service(12'hFFF, lat, ch, m);
        pop(v);
        chk("R7 truncated left word", v, (65520 << 4) & 16'hFFFF);

        // overflow and underflow: R10 R11
        for (int p = 0; p < 4; p++) accm1_t[p] = 0;
        apply_cfg();
        cfg_burst = 0; cfg_left_just = 0;
        do_reset();
        exp_q.delete();
        for (int i = 0; i < DEPTH + 1; i++) begin
            run_slot(0, sum, m10);
            exp_q.push_back(sum);
        end
        chk("R10 level held at depth", fifo_level, DEPTH);
        chk("R10 overflow flag", flags[2], 1);
        for (int i = 0; i < DEPTH; i++) begin
            pop(v);
            chk("R10 kept words", v, exp_q[i]);
        end
        last_v = v;
        chk("R11 flag clear before", flags[3], 0);
        pop(v);
        chk("R11 empty read keeps data", v, last_v);
        chk("R11 underflow flag", flags[3], 1);

        // R12 W1C and R13 irq
        chk("R12 conv flag", flags[0], 1);
        chk("R12 result flag", flags[1], 1);
        clr(6'b000100);
        chk("R12 overflow cleared", flags[2], 0);
        chk("R12 others kept", flags & 6'b001011, 6'b001011);
        @(negedge clk) irq_en = 6'b000100;
        #1 chk("R13 irq masked", irq, 0);
        irq_en = 6'b001000;
        #1 chk("R13 irq enabled", irq, 1);
        irq_en = 0;
        #1 chk("R13 irq off", irq, 0);

        // R14 busy trigger ignored in burst
        settle_t[0] = 10; accm1_t[0] = 1;
        apply_cfg();
        cfg_burst = 1;
        do_reset();
        sw_trig();
        sw_trig();
        service(12'd100, lat, ch, m);
        service(12'd200, lat, ch, m);
        req_seen = 0;
        repeat (20) @(negedge clk);
        chk("R14 no extra request", req_seen, 0);
        chk("R14 single result", fifo_level, 1);
        pop(v);
        chk("R4 burst sum", v, 300);

        // R14 hardware trigger disabled, then R3 enabled latency
        cfg_burst = 0; accm1_t[0] = 0; apply_cfg();
        cfg_hw_trig_en = 0;
        req_seen = 0;
        @(negedge clk) hw_trig = 1;
        repeat (10) @(negedge clk);
        hw_trig = 0;
        repeat (5) @(negedge clk);
        chk("R14 disabled hw trigger", req_seen, 0);
        cfg_hw_trig_en = 1;
        @(negedge clk) hw_trig = 1;
        service(12'd77, lat, ch, m);
        hw_trig = 0;
        chk("R3 hw trigger latency", lat, 3);
        pop(v);
        chk("R3 hw result", v, 77);

        finish_tb();
    end
endmodule